// File: doc/BRIEF.md
# Data Address Breakpoint Unit

This block sits beside a processor's load/store path and compares every data access against two breakpoint registers. Each register holds a doubleword compare address, a read enable, a write enable and a translation-mode bit. An access counts as a breakpoint hit only when three things are true: the access direction is enabled in that register, the register's translation bit equals the core's live data-translation state, and the address agrees above the low three bits.

A hit stops the access from completing. The block then raises a one-cycle debug exception request and records three things: the full data address, the address of the issuing instruction, and a breakpoint flag in a status word. It ignores further accesses until a resume input arrives. After resume, the next access is the replay of the interrupted one. If that access carries the same data and instruction addresses, it completes without a second breakpoint. All outputs are registered, so every result appears one clock after the access is presented.

Top module: `dbkpt_unit`

## Requirements
- R1: After reset both breakpoint registers are cleared, so no access raises an exception until software programs one. A register is written through `cfg_we`/`cfg_sel`/`cfg_wdata`, and `cfg_sel` picks register 1 (0) or register 2 (1).
- R2: Written word layout, with bit 0 as the least significant bit: bits [31:3] hold the compare address, bit 2 the translation bit, bit 1 the write enable and bit 0 the read enable.
- R3: A read access (`acc_write`=0) can match only a register whose read enable is set, and a write access can match only a register whose write enable is set. A register with both enables clear never matches.
- R4: A match also needs the register's translation bit to equal `xlat_en` in the cycle of the access.
- R5: Address bits [2:0] play no part in the compare (8-byte granularity). The captured data address is nevertheless the full address of the access.
- R6: Each access gives a result in the following cycle. An access with no hit pulses `acc_go` for one cycle. An access with a hit keeps `acc_go` low and pulses `exc_req` for one cycle instead.
- R7: With the exception, `dar_o` takes the access address, `srr0_o` takes `acc_iaddr`, and bit 22 of `exc_status` is set (all other status bits are zero). These values hold until the next exception.
- R8: `hit_o[i]` reports register i+1 matching the access. When both registers match, both bits are set and `exc_src` reads 0 (register 1 wins).
- R9: Between an exception and `resume`, accesses are ignored: no `acc_go`, no new exception, and the captured values do not change.
- R10: While held, `resume` clears the status bit. The next access then completes with `acc_go` and no exception, provided its data address equals `dar_o` and its instruction address equals `srr0_o`. Any next access, replay or not, cancels this exemption.
- R11: `resume` outside the held state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Breakpoint register write strobe |
| cfg_sel | input | 1 | Register select (0 = register 1) |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Data access presented this cycle |
| acc_write | input | 1 | Access is a store |
| acc_addr | input | 32 | Effective data address |
| acc_iaddr | input | 32 | Address of the issuing instruction |
| xlat_en | input | 1 | Live data-translation enable |
| resume | input | 1 | Return from the breakpoint exception |
| acc_go | output | 1 | Access allowed to complete |
| exc_req | output | 1 | Breakpoint exception request pulse |
| hit_o | output | 2 | Per-register match flags |
| exc_src | output | 1 | Register that won the capture |
| dar_o | output | 32 | Captured data address |
| srr0_o | output | 32 | Captured instruction address |
| exc_status | output | 32 | Exception status word (bit 22 = breakpoint) |

## Verification
The bound checker watches several properties on every cycle:
- an exception never coincides with `acc_go`;
- an exception always has a hit flag and the status bit;
- the request is a single-cycle pulse;
- register 1 wins a double hit;
- captured addresses hold while the status bit stays set.

Field decoding, the translation-bit qualifier, granularity, the held-state blocking, the one-shot replay exemption and the ignored resume depend on programmed register contents and on sequences of events. The bench's directed scenarios and its reference model under random traffic are what demonstrate these.

// File: rtl/dbkpt_pkg.sv
package dbkpt_pkg;
  // Field positions in the breakpoint register word (bit 0 = LSB)
  localparam int unsigned BP_REN_BIT  = 0;
  localparam int unsigned BP_WEN_BIT  = 1;
  localparam int unsigned BP_BT_BIT   = 2;
  localparam int unsigned BP_GRAN     = 3;   // low address bits ignored
  // Status word position decoded by the exception handler
  localparam int unsigned STAT_W      = 32;
  localparam int unsigned STAT_BK_BIT = 22;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HELD = 1'b1
  } bk_state_e;
endpackage

// File: rtl/dbkpt_regs.sv
module dbkpt_regs
  import dbkpt_pkg::*;
#(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned AW     = 32,
  parameter int unsigned SELW   = 1
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [SELW-1:0]                     cfg_sel,
  input  logic [AW-1:0]                       cfg_wdata,
  output logic [NUM_BP-1:0][AW-BP_GRAN-1:0]   cmp_o,
  output logic [NUM_BP-1:0]                   bt_o,
  output logic [NUM_BP-1:0]                   wen_o,
  output logic [NUM_BP-1:0]                   ren_o
);
  localparam int unsigned CW = AW - BP_GRAN;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_reg
    logic [CW-1:0] cmp_q;
    logic          bt_q, wen_q, ren_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q <= '0;
        bt_q  <= 1'b0;
        wen_q <= 1'b0;
        ren_q <= 1'b0;
      end else if (cfg_we && (cfg_sel == SELW'(i))) begin
        cmp_q <= cfg_wdata[AW-1:BP_GRAN];
        bt_q  <= cfg_wdata[BP_BT_BIT];
        wen_q <= cfg_wdata[BP_WEN_BIT];
        ren_q <= cfg_wdata[BP_REN_BIT];
      end
    end

    assign cmp_o[i] = cmp_q;
    assign bt_o[i]  = bt_q;
    assign wen_o[i] = wen_q;
    assign ren_o[i] = ren_q;
  end
endmodule

// File: rtl/dbkpt_match.sv
module dbkpt_match
  import dbkpt_pkg::*;
#(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned AW     = 32
) (
  input  logic                                acc_valid,
  input  logic                                acc_write,
  input  logic [AW-BP_GRAN-1:0]               acc_dw,
  input  logic                                xlat_en,
  input  logic [NUM_BP-1:0][AW-BP_GRAN-1:0]   cmp_i,
  input  logic [NUM_BP-1:0]                   bt_i,
  input  logic [NUM_BP-1:0]                   wen_i,
  input  logic [NUM_BP-1:0]                   ren_i,
  output logic [NUM_BP-1:0]                   hit_o
);
  for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
    logic dir_ok, mode_ok, addr_ok;
    assign dir_ok  = acc_write ? wen_i[i] : ren_i[i];
    assign mode_ok = (bt_i[i] == xlat_en);
    assign addr_ok = (acc_dw == cmp_i[i]);
    assign hit_o[i] = acc_valid && dir_ok && mode_ok && addr_ok;
  end
endmodule

// File: rtl/dbkpt_capture.sv
module dbkpt_capture
  import dbkpt_pkg::*;
#(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned AW     = 32,
  parameter int unsigned SELW   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [AW-1:0]      acc_addr,
  input  logic [AW-1:0]      acc_iaddr,
  input  logic [NUM_BP-1:0]  hit_raw,
  input  logic               resume,
  output logic               acc_go_o,
  output logic               exc_req_o,
  output logic [NUM_BP-1:0]  hit_o,
  output logic [SELW-1:0]    src_o,
  output logic [AW-1:0]      dar_o,
  output logic [AW-1:0]      srr0_o,
  output logic [STAT_W-1:0]  status_o
);
  bk_state_e         state_q;
  logic              skip_q, stat_q;
  logic [SELW-1:0]   win;
  logic              replay;

  // Lowest-numbered register takes priority
  always_comb begin
    win = '0;
    for (int i = NUM_BP - 1; i >= 0; i--) begin
      if (hit_raw[i]) win = SELW'(i);
    end
  end

  assign replay = skip_q && (acc_addr == dar_o) && (acc_iaddr == srr0_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      skip_q    <= 1'b0;
      stat_q    <= 1'b0;
      acc_go_o  <= 1'b0;
      exc_req_o <= 1'b0;
      hit_o     <= '0;
      src_o     <= '0;
      dar_o     <= '0;
      srr0_o    <= '0;
    end else begin
      acc_go_o  <= 1'b0;
      exc_req_o <= 1'b0;
      hit_o     <= '0;
      if (state_q == ST_HELD) begin
        if (resume) begin
          state_q <= ST_RUN;
          skip_q  <= 1'b1;
          stat_q  <= 1'b0;
        end
      end else if (acc_valid) begin
        skip_q <= 1'b0;
        if ((|hit_raw) && !replay) begin
          state_q   <= ST_HELD;
          exc_req_o <= 1'b1;
          hit_o     <= hit_raw;
          src_o     <= win;
          dar_o     <= acc_addr;
          srr0_o    <= acc_iaddr;
          stat_q    <= 1'b1;
        end else begin
          acc_go_o <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    status_o              = '0;
    status_o[STAT_BK_BIT] = stat_q;
  end
endmodule

// File: rtl/dbkpt_unit.sv
module dbkpt_unit
  import dbkpt_pkg::*;
#(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned AW     = 32,
  localparam int unsigned SELW  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
  localparam int unsigned CW    = AW - BP_GRAN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SELW-1:0]    cfg_sel,
  input  logic [AW-1:0]      cfg_wdata,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [AW-1:0]      acc_addr,
  input  logic [AW-1:0]      acc_iaddr,
  input  logic               xlat_en,
  input  logic               resume,
  output logic               acc_go,
  output logic               exc_req,
  output logic [NUM_BP-1:0]  hit_o,
  output logic [SELW-1:0]    exc_src,
  output logic [AW-1:0]      dar_o,
  output logic [AW-1:0]      srr0_o,
  output logic [STAT_W-1:0]  exc_status
);
  logic [NUM_BP-1:0][CW-1:0] cmp;
  logic [NUM_BP-1:0]         bt, wen, ren, hit_raw;

  dbkpt_regs #(.NUM_BP(NUM_BP), .AW(AW), .SELW(SELW)) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cmp_o(cmp), .bt_o(bt), .wen_o(wen), .ren_o(ren)
  );

  dbkpt_match #(.NUM_BP(NUM_BP), .AW(AW)) match_i (
    .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_dw(acc_addr[AW-1:BP_GRAN]), .xlat_en(xlat_en),
    .cmp_i(cmp), .bt_i(bt), .wen_i(wen), .ren_i(ren), .hit_o(hit_raw)
  );

  dbkpt_capture #(.NUM_BP(NUM_BP), .AW(AW), .SELW(SELW)) cap_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_iaddr(acc_iaddr), .hit_raw(hit_raw), .resume(resume),
    .acc_go_o(acc_go), .exc_req_o(exc_req), .hit_o(hit_o), .src_o(exc_src),
    .dar_o(dar_o), .srr0_o(srr0_o), .status_o(exc_status)
  );
endmodule

// File: rtl/dbkpt_unit_chk.sv
module dbkpt_unit_chk
  import dbkpt_pkg::*;
#(
  parameter int unsigned NUM_BP = 2,
  parameter int unsigned AW     = 32,
  parameter int unsigned SELW   = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_go,
  input logic               exc_req,
  input logic [NUM_BP-1:0]  hit_o,
  input logic [SELW-1:0]    exc_src,
  input logic [AW-1:0]      dar_o,
  input logic [AW-1:0]      srr0_o,
  input logic [STAT_W-1:0]  exc_status
);
  p_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> !acc_go);
  p_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (|hit_o));
  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    exc_req |=> !exc_req);
  p_status_r7: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> exc_status[STAT_BK_BIT]);
  p_status_clean_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(exc_status) <= 1);
  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    (exc_req && hit_o[0]) |-> (exc_src == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (exc_status[STAT_BK_BIT] && !exc_req) |-> ($stable(dar_o) && $stable(srr0_o)));
endmodule

bind dbkpt_unit dbkpt_unit_chk #(.NUM_BP(NUM_BP), .AW(AW), .SELW(SELW)) chk_i (
  .clk(clk), .rst(rst), .acc_go(acc_go), .exc_req(exc_req), .hit_o(hit_o),
  .exc_src(exc_src), .dar_o(dar_o), .srr0_o(srr0_o), .exc_status(exc_status)
);

// File: tb/dbkpt_unit_tb_top.sv
module dbkpt_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        acc_valid = 0, acc_write = 0, xlat_en = 0, resume = 0;
  logic [31:0] acc_addr = 0, acc_iaddr = 0;
  logic        acc_go, exc_req, exc_src;
  logic [1:0]  hit_o;
  logic [31:0] dar_o, srr0_o, exc_status;

  int checks = 0, errors = 0;

  // reference model state
  logic [31:0] m_reg [2];
  logic        m_held = 0, m_skip = 0;
  logic        e_go = 0, e_exc = 0, e_src = 0, e_stat = 0;
  logic [1:0]  e_hit = 0;
  logic [31:0] e_dar = 0, e_srr0 = 0;

  always #2 clk = ~clk;  // 250 MHz

  dbkpt_unit dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_iaddr(acc_iaddr), .xlat_en(xlat_en), .resume(resume),
    .acc_go(acc_go), .exc_req(exc_req), .hit_o(hit_o), .exc_src(exc_src),
    .dar_o(dar_o), .srr0_o(srr0_o), .exc_status(exc_status)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2/R3/R4/R5 matching rule computed from the requirements
  function automatic logic [1:0] m_hits(input logic [31:0] a, input logic w, input logic xl);
    logic [1:0] h;
    for (int i = 0; i < 2; i++) begin
      logic en;
      en = w ? m_reg[i][1] : m_reg[i][0];
      h[i] = en && (m_reg[i][2] == xl) && (a[31:3] == m_reg[i][31:3]);
    end
    return h;
  endfunction

  task automatic step(input logic v, input logic w, input logic [31:0] a, input logic [31:0] ia,
                      input logic xl, input logic rs, input logic cwe, input logic csel,
                      input logic [31:0] cwd);
    logic [1:0] h;
    logic rep;
    acc_valid = v; acc_write = w; acc_addr = a; acc_iaddr = ia; xlat_en = xl;
    resume = rs; cfg_we = cwe; cfg_sel = csel; cfg_wdata = cwd;
    e_go = 0; e_exc = 0; e_hit = 0;
    if (m_held) begin
      if (rs) begin m_held = 0; m_skip = 1; e_stat = 0; end
    end else if (v) begin
      rep = m_skip && a == e_dar && ia == e_srr0;
      m_skip = 0;
      h = m_hits(a, w, xl);
      if (h != 0 && !rep) begin
        m_held = 1; e_exc = 1; e_hit = h; e_src = h[0] ? 1'b0 : 1'b1;
        e_dar = a; e_srr0 = ia; e_stat = 1;
      end else e_go = 1;
    end
    if (cwe) m_reg[csel] = cwd;
    @(posedge clk);
    @(negedge clk);
    chk(acc_go == e_go, "R6 acc_go", 32'(acc_go), 32'(e_go));
    chk(exc_req == e_exc, "R6 exc_req", 32'(exc_req), 32'(e_exc));
    chk(hit_o == e_hit, "R8 hit_o", 32'(hit_o), 32'(e_hit));
    chk(exc_src == e_src, "R8 exc_src", 32'(exc_src), 32'(e_src));
    chk(dar_o == e_dar, "R7 dar_o", dar_o, e_dar);
    chk(srr0_o == e_srr0, "R7 srr0_o", srr0_o, e_srr0);
    chk(exc_status == (32'(e_stat) << 22), "R7 exc_status", exc_status, 32'(e_stat) << 22);
  endtask

  task automatic acc(input logic w, input logic [31:0] a, input logic [31:0] ia, input logic xl);
    step(1, w, a, ia, xl, 0, 0, 0, 0);
  endtask
  task automatic res();
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic wr(input logic sel, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 1, sel, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reg[0] = 0; m_reg[1] = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state
    chk(acc_go == 0 && exc_req == 0 && hit_o == 0, "R1 reset outputs", {29'b0, acc_go, hit_o}, 0);
    chk(exc_status == 0 && dar_o == 0, "R1 reset capture", exc_status | dar_o, 0);

    // R1/R3: cleared registers match nothing, even at address 0
    acc(0, 32'h0, 32'h400, 0);
    chk(acc_go == 1 && exc_req == 0, "R1 cleared regs no match", 32'(exc_req), 0);
    acc(1, 32'h4, 32'h404, 0);
    chk(exc_req == 0, "R3 no enables no match", 32'(exc_req), 0);

    // R2: reg1 = 0x1000, bt0, rd+wr ; reg2 = 0x1000, bt1, wr only
    wr(0, 32'h0000_1003);
    wr(1, 32'h0000_1006);

    // R4: translation mismatch on reg1, reg2 read disabled
    acc(0, 32'h1005, 32'h500, 1);
    chk(acc_go == 1 && exc_req == 0, "R4 bt mismatch no hit", 32'(exc_req), 0);

    // R5: low bits ignored, full address captured
    acc(0, 32'h1005, 32'h504, 0);
    chk(exc_req == 1 && dar_o == 32'h1005, "R5 granularity capture", dar_o, 32'h1005);
    chk(exc_status == 32'h0040_0000, "R7 status bit 22", exc_status, 32'h0040_0000);

    // R9: held state ignores accesses
    acc(0, 32'h2000, 32'h508, 0);
    chk(acc_go == 0 && dar_o == 32'h1005, "R9 held ignores", dar_o, 32'h1005);

    // R10: resume then replay completes
    res();
    chk(exc_status == 0, "R10 resume clears status", exc_status, 0);
    acc(0, 32'h1005, 32'h504, 0);
    chk(acc_go == 1 && exc_req == 0, "R10 replay completes", 32'(acc_go), 1);

    // R2/R3: write hits reg2 via bit 2 and bit 1
    acc(1, 32'h1000, 32'h600, 1);
    chk(exc_req == 1 && hit_o == 2'b10 && exc_src == 1, "R2 reg2 write hit", 32'(hit_o), 2);
    res();
    acc(0, 32'h3000, 32'h604, 1);   // consumes exemption
    acc(1, 32'h1000, 32'h600, 1);
    chk(exc_req == 1, "R10 exemption consumed", 32'(exc_req), 1);
    res();

    // R8: both registers hit, register 1 wins
    wr(0, 32'h0000_1006);
    acc(1, 32'h1001, 32'h700, 1);
    chk(hit_o == 2'b11 && exc_src == 0, "R8 dual hit priority", {30'b0, hit_o}, 3);
    res();
    acc(0, 32'h3000, 32'h704, 1);
    // R11: resume while running has no effect
    res();
    chk(exc_status == 0 && acc_go == 0, "R11 idle resume", exc_status, 0);
    acc(1, 32'h1001, 32'h700, 1);
    chk(exc_req == 1, "R11 no exemption granted", 32'(exc_req), 1);
    res();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [31:0] a, ia;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        logic [31:0] base;
        base = ($urandom_range(0, 2) == 0) ? 32'h1000 : {$urandom_range(0, 3), 3'b000} + 32'h1000;
        wr(1'($urandom_range(0, 1)), {base[31:3], 3'($urandom_range(0, 7))});
      end else if (m_held && r < 40) begin
        res();
      end else if (r < 90) begin
        if (m_skip && $urandom_range(0, 1) == 1) begin a = e_dar; ia = e_srr0; end
        else begin
          a = 32'h1000 + 32'($urandom_range(0, 31));
          ia = 32'h8000 + {28'($urandom_range(0, 15)), 2'b00};
        end
        step(1, 1'($urandom_range(0, 1)), a, ia, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 9) == 0), 0, 0, 0);
      end else begin
        step(0, 0, 0, 0, 0, 1'($urandom_range(0, 1)), 0, 0, 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule